// File: doc/BRIEF.md
# Dual-Mode 64-bit Register File

This block is the architectural register store of a 64-bit load/store datapath. It holds thirty-two 64-bit general entries and serves two combinational read ports and one write port. Each port carries an entry index, a width select (64-bit or 32-bit) and a per-access mode flag for the top index. That flag decides whether index 31 behaves as a hard-wired zero source and discard sink, or as a real stack-pointer entry. The block also keeps the four condition flags (negative, zero, carry, overflow), which are loaded together through their own enable, and the program counter, which has its own load port.

Narrow (32-bit) accesses follow a fixed rule. A narrow read gives the low half of the entry with the upper half of the output at zero. A narrow write stores the low half and clears the upper half of the entry.

A synchronous active-low reset puts the block into a known state. The stack-pointer entry is loaded with a configurable stack-top value. The link entry (index 30) and the program counter are loaded with a configurable invalid-address marker. Everything else clears to zero.

Top module: `dm_regfile`

## Requirements
- R1: The file holds 32 entries of 64 bits. When `wr_en` is high at a rising clock edge, entry `wr_idx` is written. Both read ports return the addressed entry combinationally.
- R2: A read of index 31 with its mode flag low (zero-register mode) returns all zeros.
- R3: A write to index 31 with `wr_sp` low is discarded. A later stack-pointer-mode read of index 31 still shows the earlier value.
- R4: With the mode flag high (stack-pointer mode), index 31 is read and written like any other entry.
- R5: A write with `wr_wide` low (32-bit) stores `wr_data[31:0]` in bits 31:0 and zeros in bits 63:32 of the entry.
- R6: A read with its width select low (32-bit) returns bits 31:0 of the entry, with bits 63:32 of the output at zero. A width select of 1 means 64-bit.
- R7: A clock edge with `rst_n` low resets the state. Entries 0 to 29 become zero, entry 31 becomes `STACK_TOP`, entry 30 becomes `BAD_ADDR`, the flags become 0000 and `pc` becomes `BAD_ADDR`. Writes at that edge are ignored.
- R8: A read of the index being written in the same cycle returns the value held before the edge.
- R9: `flags` is {N,Z,C,V} in bits 3 down to 0. When `flg_en` is high at an edge, all four are loaded from `flg_in`. Otherwise they hold.
- R10: When `pc_en` is high at an edge, `pc` loads `pc_next`. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ra_idx | input | 5 | Read port A index |
| ra_wide | input | 1 | Read port A width: 1 = 64-bit, 0 = 32-bit |
| ra_sp | input | 1 | Read port A index-31 mode: 1 = stack pointer, 0 = zero |
| ra_data | output | 64 | Read port A data |
| rb_idx | input | 5 | Read port B index |
| rb_wide | input | 1 | Read port B width select |
| rb_sp | input | 1 | Read port B index-31 mode |
| rb_data | output | 64 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write index |
| wr_wide | input | 1 | Write width: 1 = 64-bit, 0 = 32-bit |
| wr_sp | input | 1 | Write index-31 mode |
| wr_data | input | 64 | Write data |
| flg_en | input | 1 | Condition flag load enable |
| flg_in | input | 4 | New flags {N,Z,C,V} |
| flags | output | 4 | Current flags {N,Z,C,V} |
| pc_en | input | 1 | Program counter load enable |
| pc_next | input | 64 | New program counter value |
| pc | output | 64 | Current program counter |

## Verification
The bench targets several corner cases.
- **Index 31 in both modes.** A design that ignores the mode would leak the stack pointer into zero-mode reads, or let zero-mode writes overwrite it.
- **Narrow accesses.** The data patterns have ones in every upper half, so a design that kept stale upper bits on a 32-bit write, or failed to mask a 32-bit read, shows a mismatch.
- **Same-cycle read and write.** Read-after-write on one index would expose a bypass that returns the new value too early.
- **Reset.** A second reset in the middle of the run checks that stack-top and marker values are reloaded, and that stray writes during reset do not land.

// File: rtl/dm_regfile_pkg.sv
// Package: shared constants and types for the dual-mode register file.
// Assumes a power-of-two entry count; the top index is the dual-mode one.
package dm_regfile_pkg;

    // Condition flag vector layout: bit 3 N, bit 2 Z, bit 1 C, bit 0 V
    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } cond_flags_t;

    localparam int FLAG_BITS = 4;

    // Width select encoding on every port
    localparam logic WIDTH_NARROW = 1'b0;
    localparam logic WIDTH_FULL   = 1'b1;

endpackage

// File: rtl/dm_rf_storage.sv
// Module: entry array with one write port.
// Does: holds NREGS entries of W bits. Drops zero-mode writes to the top
// index, zero-extends narrow writes and loads reset values.
// Assumes: a synchronous active-low reset; writes are ignored during reset.
module dm_rf_storage #(
    parameter int          NREGS     = 32,
    parameter int          W         = 64,
    parameter logic [63:0] STACK_TOP = 64'h0000_0000_0010_0000,
    parameter logic [63:0] BAD_ADDR  = 64'hDEAD_BEEF_DEAD_BEEF,
    localparam int         IDX_W     = $clog2(NREGS),
    localparam int         HALF      = W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_wide,
    input  logic             wr_sp,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     ents [NREGS]
);
    import dm_regfile_pkg::*;

    localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(NREGS - 1);
    localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'(NREGS - 2);

    logic         wr_drop;
    logic [W-1:0] wr_val;

    // Decide whether the write lands and shape the value for its width
    always_comb begin
        wr_drop = (wr_idx == TOP_IDX) && !wr_sp;
        if (wr_wide == WIDTH_FULL) wr_val = wr_data;
        else                       wr_val = {{(W-HALF){1'b0}}, wr_data[HALF-1:0]};
    end

    // Register array update with reset preset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) ents[i] <= '0;
            ents[TOP_IDX]  <= STACK_TOP[W-1:0];
            ents[LINK_IDX] <= BAD_ADDR[W-1:0];
        end else if (wr_en && !wr_drop) begin
            ents[wr_idx] <= wr_val;
        end
    end

    // R3
    zr_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == TOP_IDX && !wr_sp) |=> $stable(ents[TOP_IDX]));

    // R5
    narrow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_wide && (wr_idx != TOP_IDX || wr_sp))
            |=> ents[$past(wr_idx)][W-1:HALF] == '0);

    // R7
    reset_stack_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ents[TOP_IDX] == STACK_TOP[W-1:0]
                          && ents[LINK_IDX] == BAD_ADDR[W-1:0]));

endmodule

// File: rtl/dm_rf_read_port.sv
// Module: one combinational read port.
// Does: selects an entry, substitutes zero for the top index in zero mode
// and masks the upper half on narrow reads.
// Assumes: the entry array is driven by the storage module.
module dm_rf_read_port #(
    parameter int  NREGS = 32,
    parameter int  W     = 64,
    localparam int IDX_W = $clog2(NREGS),
    localparam int HALF  = W / 2
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             wide,
    input  logic             sp_mode,
    input  logic [W-1:0]     ents [NREGS],
    output logic [W-1:0]     data
);
    import dm_regfile_pkg::*;

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NREGS - 1);

    logic [W-1:0] raw;

    // Entry select with zero-register substitution
    always_comb begin
        if (idx == TOP_IDX && !sp_mode) raw = '0;
        else                            raw = ents[idx];
    end

    // Width shaping of the read result
    always_comb begin
        if (wide == WIDTH_FULL) data = raw;
        else                    data = {{(W-HALF){1'b0}}, raw[HALF-1:0]};
    end

    // Output-side checks against the storage contents
    always_comb begin
        if (wide == WIDTH_NARROW) begin
            // R6
            narrow_read_chk: assert (data[W-1:HALF] == '0 &&
                                     data[HALF-1:0] == ((idx == TOP_IDX && !sp_mode)
                                         ? '0 : ents[idx][HALF-1:0]));
        end
        if (idx == TOP_IDX && sp_mode == 1'b0) begin
            // R2
            zr_read_chk: assert (data == '0);
        end
    end

endmodule

// File: rtl/dm_rf_ctrl_state.sv
// Module: condition flags and program counter.
// Does: loads all four flags together under their enable, and loads
// the program counter under its enable.
// Assumes: a synchronous active-low reset; the program counter resets to the
// invalid marker.
module dm_rf_ctrl_state #(
    parameter int          W        = 64,
    parameter logic [63:0] BAD_ADDR = 64'hDEAD_BEEF_DEAD_BEEF
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    flg_en,
    input  logic [dm_regfile_pkg::FLAG_BITS-1:0]    flg_in,
    output logic [dm_regfile_pkg::FLAG_BITS-1:0]    flags,
    input  logic                                    pc_en,
    input  logic [W-1:0]                            pc_next,
    output logic [W-1:0]                            pc
);
    import dm_regfile_pkg::*;

    cond_flags_t flags_q;

    // Flag register: all four bits load as one
    always_ff @(posedge clk) begin
        if (!rst_n)      flags_q <= '0;
        else if (flg_en) flags_q <= cond_flags_t'(flg_in);
    end

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n)     pc <= BAD_ADDR[W-1:0];
        else if (pc_en) pc <= pc_next;
    end

    assign flags = flags_q;

    // R9
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flg_en && $past(rst_n)) |=> $stable(flags));

    // R10
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_en && $past(rst_n)) |=> $stable(pc));

    // R10
    pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_en |=> pc == $past(pc_next));

endmodule

// File: rtl/dm_regfile.sv
// Module: top of the dual-mode register file.
// Does: connects the entry storage, two read ports (built by generate) and
// the flag/PC state.
// Assumes: all ports are synchronous to clk; reads are combinational.
module dm_regfile #(
    parameter int          NREGS     = 32,
    parameter int          W         = 64,
    parameter logic [63:0] STACK_TOP = 64'h0000_0000_0010_0000,
    parameter logic [63:0] BAD_ADDR  = 64'hDEAD_BEEF_DEAD_BEEF,
    localparam int         IDX_W     = $clog2(NREGS),
    localparam int         NRD       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    input  logic             ra_wide,
    input  logic             ra_sp,
    output logic [W-1:0]     ra_data,
    input  logic [IDX_W-1:0] rb_idx,
    input  logic             rb_wide,
    input  logic             rb_sp,
    output logic [W-1:0]     rb_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_wide,
    input  logic             wr_sp,
    input  logic [W-1:0]     wr_data,
    input  logic             flg_en,
    input  logic [3:0]       flg_in,
    output logic [3:0]       flags,
    input  logic             pc_en,
    input  logic [W-1:0]     pc_next,
    output logic [W-1:0]     pc
);
    logic [W-1:0]     ents [NREGS];
    logic [IDX_W-1:0] rd_idx  [NRD];
    logic             rd_wide [NRD];
    logic             rd_sp   [NRD];
    logic [W-1:0]     rd_data [NRD];

    // Gather read-port controls into arrays for the generate loop
    always_comb begin
        rd_idx[0] = ra_idx;  rd_wide[0] = ra_wide;  rd_sp[0] = ra_sp;
        rd_idx[1] = rb_idx;  rd_wide[1] = rb_wide;  rd_sp[1] = rb_sp;
    end

    assign ra_data = rd_data[0];
    assign rb_data = rd_data[1];

    dm_rf_storage #(
        .NREGS(NREGS), .W(W), .STACK_TOP(STACK_TOP), .BAD_ADDR(BAD_ADDR)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_wide(wr_wide), .wr_sp(wr_sp), .wr_data(wr_data), .ents(ents)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        dm_rf_read_port #(.NREGS(NREGS), .W(W)) u_rd (
            .idx(rd_idx[p]), .wide(rd_wide[p]), .sp_mode(rd_sp[p]),
            .ents(ents), .data(rd_data[p])
        );
    end

    dm_rf_ctrl_state #(.W(W), .BAD_ADDR(BAD_ADDR)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flg_en(flg_en), .flg_in(flg_in),
        .flags(flags), .pc_en(pc_en), .pc_next(pc_next), .pc(pc)
    );

    // R8
    old_value_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sp && ra_sp && ra_wide && ra_idx == wr_idx)
            |-> ra_data == ents[ra_idx]);

endmodule

// File: tb/dm_regfile_test.sv
module dm_regfile_test;
    localparam logic [63:0] STK = 64'h0000_0000_0010_0000;
    localparam logic [63:0] BAD = 64'hDEAD_BEEF_DEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ra_idx = '0, rb_idx = '0, wr_idx = '0;
    logic        ra_wide = 1'b1, ra_sp = 1'b1, rb_wide = 1'b1, rb_sp = 1'b1;
    logic        wr_en = 1'b0, wr_wide = 1'b1, wr_sp = 1'b1;
    logic [63:0] wr_data = '0, pc_next = '0;
    logic        flg_en = 1'b0, pc_en = 1'b0;
    logic [3:0]  flg_in = '0;
    logic [63:0] ra_data, rb_data, pc;
    logic [3:0]  flags;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string tag = "R7";

    logic [63:0] m_reg [32];
    logic [3:0]  m_flg;
    logic [63:0] m_pc;

    always #10 clk = ~clk;

    dm_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(ra_idx), .ra_wide(ra_wide), .ra_sp(ra_sp), .ra_data(ra_data),
        .rb_idx(rb_idx), .rb_wide(rb_wide), .rb_sp(rb_sp), .rb_data(rb_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_wide(wr_wide), .wr_sp(wr_sp),
        .wr_data(wr_data), .flg_en(flg_en), .flg_in(flg_in), .flags(flags),
        .pc_en(pc_en), .pc_next(pc_next), .pc(pc)
    );

    function automatic logic [63:0] model_read(logic [4:0] i, logic w, logic s);
        logic [63:0] v;
        v = (i == 5'd31 && !s) ? 64'd0 : m_reg[i];
        return w ? v : {32'd0, v[31:0]};
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One clock: compare before the edge, then advance the model
    task automatic cyc();
        #1;
        check(tag, "port A", ra_data, model_read(ra_idx, ra_wide, ra_sp));
        check(tag, "port B", rb_data, model_read(rb_idx, rb_wide, rb_sp));
        check(tag, "flags", {60'd0, flags}, {60'd0, m_flg});
        check(tag, "pc", pc, m_pc);
        @(posedge clk);
        if (!rst_n) begin
            foreach (m_reg[i]) m_reg[i] = '0;
            m_reg[31] = STK; m_reg[30] = BAD; m_flg = '0; m_pc = BAD;
        end else begin
            if (wr_en && !(wr_idx == 5'd31 && !wr_sp))
                m_reg[wr_idx] = wr_wide ? wr_data : {32'd0, wr_data[31:0]};
            if (flg_en) m_flg = flg_in;
            if (pc_en)  m_pc = pc_next;
        end
        @(negedge clk);
    endtask

    task automatic wr(logic [4:0] i, logic w, logic s, logic [63:0] d);
        wr_en = 1'b1; wr_idx = i; wr_wide = w; wr_sp = s; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, logic aw, logic as_, logic [4:0] b, logic bw, logic bs);
        ra_idx = a; ra_wide = aw; ra_sp = as_; rb_idx = b; rb_wide = bw; rb_sp = bs;
        cyc();
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        foreach (m_reg[i]) m_reg[i] = 'x;
        m_flg = 'x; m_pc = 'x;
        @(negedge clk);
        // R7: reset with a stray write and flag/pc loads that must be ignored
        wr_en = 1'b1; wr_idx = 5'd3; wr_data = 64'h1234; flg_en = 1'b1; flg_in = 4'hF;
        pc_en = 1'b1; pc_next = 64'h40;
        @(posedge clk);
        foreach (m_reg[i]) m_reg[i] = '0;
        m_reg[31] = STK; m_reg[30] = BAD; m_flg = '0; m_pc = BAD;
        @(negedge clk);
        cyc();
        wr_en = 1'b0; flg_en = 1'b0; pc_en = 1'b0;
        rst_n = 1'b1;
        for (int i = 0; i < 32; i += 2) rd(5'(i), 1'b1, 1'b1, 5'(i + 1), 1'b1, 1'b1);

        // R1: full-width writes to every ordinary entry
        tag = "R1";
        for (int i = 0; i < 31; i++)
            wr(5'(i), 1'b1, 1'b1, {32'hF0F0_0000 | 32'(i), 32'hA5A5_0000 + 32'(i * 7)});
        for (int i = 0; i < 31; i += 2) rd(5'(i), 1'b1, 1'b0, 5'(30 - i), 1'b1, 1'b0);

        // R2 / R4: index 31 in both modes on both ports
        tag = "R4";
        wr(5'd31, 1'b1, 1'b1, 64'hFFFF_0000_1234_5670);
        rd(5'd31, 1'b1, 1'b1, 5'd31, 1'b1, 1'b1);
        tag = "R2";
        rd(5'd31, 1'b1, 1'b0, 5'd31, 1'b0, 1'b0);
        rd(5'd31, 1'b1, 1'b1, 5'd31, 1'b1, 1'b0);

        // R3: zero-mode write to index 31 must leave the stack pointer alone
        tag = "R3";
        wr(5'd31, 1'b1, 1'b0, 64'h1111_2222_3333_4444);
        wr(5'd31, 1'b0, 1'b0, 64'h5555_6666_7777_8888);
        rd(5'd31, 1'b1, 1'b1, 5'd31, 1'b0, 1'b1);

        // R5: narrow writes clear the upper half
        tag = "R5";
        wr(5'd4, 1'b0, 1'b0, 64'hFFFF_FFFF_8000_0001);
        wr(5'd31, 1'b0, 1'b1, 64'hCAFE_CAFE_0000_FFF0);
        rd(5'd4, 1'b1, 1'b0, 5'd31, 1'b1, 1'b1);

        // R6: narrow reads mask the upper half of a full entry
        tag = "R6";
        rd(5'd5, 1'b0, 1'b0, 5'd6, 1'b0, 1'b1);
        rd(5'd31, 1'b0, 1'b1, 5'd31, 1'b0, 1'b0);

        // R8: read the index being written; model compare happens pre-edge
        tag = "R8";
        ra_idx = 5'd7; ra_wide = 1'b1; ra_sp = 1'b1;
        rb_idx = 5'd31; rb_wide = 1'b1; rb_sp = 1'b1;
        wr(5'd7, 1'b1, 1'b1, 64'h0123_4567_89AB_CDEF);
        wr(5'd31, 1'b1, 1'b1, 64'h0000_0000_0020_0000);
        rd(5'd7, 1'b1, 1'b1, 5'd31, 1'b1, 1'b1);

        // R9: flag loads and holds
        tag = "R9";
        flg_en = 1'b1; flg_in = 4'b1010; cyc();
        flg_in = 4'b0101; cyc();
        flg_en = 1'b0; flg_in = 4'b1111; cyc(); cyc();

        // R10: program counter loads and holds
        tag = "R10";
        pc_en = 1'b1; pc_next = 64'h0000_0000_0000_1000; cyc();
        pc_en = 1'b0; pc_next = 64'h0000_0000_0000_2000; cyc(); cyc();

        // R1: random traffic on every port
        tag = "R1";
        for (int n = 0; n < 600; n++) begin
            ra_idx = 5'($urandom); ra_wide = 1'($urandom); ra_sp = 1'($urandom);
            rb_idx = 5'($urandom); rb_wide = 1'($urandom); rb_sp = 1'($urandom);
            wr_en = 1'($urandom); wr_idx = 5'($urandom); wr_wide = 1'($urandom);
            wr_sp = 1'($urandom); wr_data = {$urandom, $urandom};
            flg_en = 1'($urandom); flg_in = 4'($urandom);
            pc_en = 1'($urandom); pc_next = {$urandom, $urandom};
            cyc();
        end
        wr_en = 1'b0; flg_en = 1'b0; pc_en = 1'b0;

        // R7: second reset mid-run
        tag = "R7";
        rst_n = 1'b0; wr_en = 1'b1; wr_idx = 5'd31; wr_sp = 1'b1; wr_data = '1;
        cyc();
        rst_n = 1'b1; wr_en = 1'b0;
        for (int i = 0; i < 32; i += 2) rd(5'(i), 1'b1, 1'b1, 5'(i + 1), 1'b1, 1'b1);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule